// File: doc/BRIEF.md
# Shifter-Based Asynchronous Serial Transmitter

This block sends one byte at a time as an asynchronous serial frame on a single output line. It does this by driving a small shift engine that always emits the top bit of its 8-bit register first. A 4-bit wrap counter inside that engine limits how many bits are sent. A byte arrives through a valid/ready handshake. The sequencer mirrors the byte so that its lowest bit is sent first. It then loads the engine twice. The first load holds the start bit and seven data bits. The second load holds the last data bit, the optional parity bit and the stop bits.

A bit-time strobe comes from a counter that clears when it matches a compare value. An optional divide-by-8 stage sits in front of that counter. The counter starts again from zero whenever a frame begins, so the start bit lasts a full bit time. All framing and timing settings are captured when the byte is accepted and stay fixed for that frame. Only transmission is covered, and only with 8 data bits.

Top module: `uart_shift_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is high and `in_ready` is high.
- R2: A byte is taken on a rising clock edge where both `in_valid` and `in_ready` are high. From the next cycle, `in_ready` stays low until the frame ends. Any `in_valid` or `in_data` activity during that time has no effect on the frame.
- R3: The frame starts with one low start bit. It begins in the first cycle after the accepting edge.
- R4: The 8 data bits follow the start bit, least significant bit first.
- R5: `cfg_parity` selects the parity bit: 2'b01 gives even parity, 2'b10 gives odd parity, and 2'b00 or 2'b11 gives no parity bit. The parity bit, when present, comes straight after data bit 7. Even parity makes the total number of ones across the data and parity bits even. Odd parity makes that total odd.
- R6: `cfg_two_stop` = 0 gives one high stop bit and 1 gives two. `in_ready` goes high again exactly at the end of the last stop bit, and the line stays high.
- R7: Each bit lasts (`cfg_compare` + 1) clock cycles. When `cfg_prescale8` = 1, each bit lasts 8 × (`cfg_compare` + 1) clock cycles.
- R8: The bit timer restarts at acceptance, so the start bit has a full bit period no matter how long the block was idle.
- R9: The values of `cfg_parity`, `cfg_two_stop`, `cfg_compare` and `cfg_prescale8` are captured at acceptance. Changes to them during a frame have no effect on that frame.
- R10: `tx_line` changes only at a bit-time boundary or at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block can take a byte |
| cfg_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_compare | input | 8 | Bit period minus one, in timer units |
| cfg_prescale8 | input | 1 | Timer unit is 8 clocks instead of 1 |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
The assertions check on every cycle these rules:
- the line is high whenever the block is ready;
- acceptance drops `in_ready` and pulls the line low on the next cycle;
- the line holds steady except on a bit strobe or at acceptance;
- `in_ready` only returns on a bit strobe.

Only the bench scenarios can show the following:
- the bit order, parity polarity and stop count, which are compared against a frame model;
- the exact bit period with and without the prescaler;
- that disturbing the handshake and settings mid-frame leaves the frame unchanged.

// File: rtl/uart_shift_tx_pkg.sv
package uart_shift_tx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_TAIL = 2'd2
    } phase_e;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;

    function automatic logic parity_active(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

endpackage

// File: rtl/bit_tick_gen.sv
module bit_tick_gen #(
    parameter int TIMER_W = 8,
    parameter int PRE_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               restart_i,
    input  logic [TIMER_W-1:0] compare_i,
    input  logic               prescale_i,
    output logic               tick_o
);
    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [TIMER_W-1:0] timer;
    } tick_state_t;

    tick_state_t t_d, t_q;
    logic        unit_stb;
    logic        match;

    always_comb begin
        unit_stb = !prescale_i || (t_q.pre == PRE_LAST);
        match    = (t_q.timer == compare_i);
        tick_o   = run_i && unit_stb && match;
        t_d      = t_q;
        if (restart_i || !run_i) begin
            t_d = '0;
        end else begin
            t_d.pre = prescale_i ? t_q.pre + 1'b1 : '0;
            if (unit_stb) begin
                t_d.timer = match ? '0 : t_q.timer + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/tx_shift_unit.sv
module tx_shift_unit #(
    parameter int SHIFT_W = 8,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [SHIFT_W-1:0] word_i,
    input  logic [CNT_W-1:0]   preset_i,
    input  logic               off_i,
    input  logic               tick_i,
    output logic               line_o,
    output logic               wrap_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic               en;
        logic [SHIFT_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } shift_state_t;

    shift_state_t s_d, s_q;

    always_comb begin
        wrap_o = s_q.en && tick_i && (s_q.cnt == CNT_LAST);
        line_o = s_q.en ? s_q.sh[SHIFT_W-1] : 1'b1;
        s_d    = s_q;
        if (off_i) begin
            s_d.en  = 1'b0;
            s_d.sh  = '1;
            s_d.cnt = '0;
        end else if (load_i) begin
            s_d.en  = 1'b1;
            s_d.sh  = word_i;
            s_d.cnt = preset_i;
        end else if (s_q.en && tick_i) begin
            s_d.sh  = {s_q.sh[SHIFT_W-2:0], 1'b1};
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{en: 1'b0, sh: '1, cnt: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import uart_shift_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 4,
    parameter int TIMER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    input  logic [1:0]         cfg_parity,
    input  logic               cfg_two_stop,
    input  logic [TIMER_W-1:0] cfg_compare,
    input  logic               cfg_prescale8,
    input  logic               wrap_i,
    output logic               load_o,
    output logic [DATA_W-1:0]  word_o,
    output logic [CNT_W-1:0]   preset_o,
    output logic               off_o,
    output logic               run_o,
    output logic               restart_o,
    output logic [TIMER_W-1:0] compare_o,
    output logic               prescale_o
);
    localparam logic [CNT_W-1:0] HEAD_PRESET = CNT_W'(2 ** CNT_W - DATA_W);

    typedef struct packed {
        phase_e             ph;
        logic               last_bit;
        logic               pbit;
        logic [1:0]         par;
        logic               stop2;
        logic [TIMER_W-1:0] cmp;
        logic               pre8;
    } seq_state_t;

    seq_state_t          q_d, q_q;
    logic [DATA_W-1:0]   mirrored;
    logic [CNT_W-1:0]    tail_len;
    logic                par_on;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) mirrored[i] = in_data[DATA_W-1-i];
        par_on   = parity_active(q_q.par);
        tail_len = CNT_W'(1) + CNT_W'(par_on) + (q_q.stop2 ? CNT_W'(2) : CNT_W'(1));
    end

    always_comb begin
        q_d       = q_q;
        load_o    = 1'b0;
        word_o    = '1;
        preset_o  = '0;
        off_o     = 1'b0;
        restart_o = 1'b0;
        case (q_q.ph)
            PH_IDLE: begin
                if (in_valid) begin
                    q_d.ph       = PH_HEAD;
                    q_d.last_bit = in_data[DATA_W-1];
                    q_d.pbit     = (^in_data) ^ (cfg_parity == PAR_ODD);
                    q_d.par      = cfg_parity;
                    q_d.stop2    = cfg_two_stop;
                    q_d.cmp      = cfg_compare;
                    q_d.pre8     = cfg_prescale8;
                    load_o       = 1'b1;
                    word_o       = {1'b0, mirrored[DATA_W-1:1]};
                    preset_o     = HEAD_PRESET;
                    restart_o    = 1'b1;
                end
            end
            PH_HEAD: begin
                if (wrap_i) begin
                    q_d.ph             = PH_TAIL;
                    load_o             = 1'b1;
                    word_o[DATA_W-1]   = q_q.last_bit;
                    if (par_on) word_o[DATA_W-2] = q_q.pbit;
                    preset_o           = CNT_W'(0) - tail_len;
                end
            end
            PH_TAIL: begin
                if (wrap_i) begin
                    q_d.ph = PH_IDLE;
                    off_o  = 1'b1;
                end
            end
            default: q_d.ph = PH_IDLE;
        endcase
    end

    assign in_ready   = (q_q.ph == PH_IDLE);
    assign run_o      = (q_q.ph != PH_IDLE);
    assign compare_o  = q_q.cmp;
    assign prescale_o = q_q.pre8;

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '{ph: PH_IDLE, default: '0};
        else        q_q <= q_d;
    end
endmodule

// File: rtl/uart_shift_tx.sv
module uart_shift_tx #(
    parameter int DATA_W  = 8,
    parameter int CNT_W   = 4,
    parameter int TIMER_W = 8,
    parameter int PRE_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    input  logic [1:0]         cfg_parity,
    input  logic               cfg_two_stop,
    input  logic [TIMER_W-1:0] cfg_compare,
    input  logic               cfg_prescale8,
    output logic               tx_line
);
    localparam int SHIFT_W = DATA_W;

    logic               bit_tick;
    logic               wrap;
    logic               load;
    logic [SHIFT_W-1:0] word;
    logic [CNT_W-1:0]   preset;
    logic               off;
    logic               run;
    logic               restart;
    logic [TIMER_W-1:0] cmp_held;
    logic               pre_held;

    tx_frame_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TIMER_W(TIMER_W)) u_seq (
        .clk, .rst_n, .in_valid, .in_data, .in_ready,
        .cfg_parity, .cfg_two_stop, .cfg_compare, .cfg_prescale8,
        .wrap_i(wrap), .load_o(load), .word_o(word), .preset_o(preset),
        .off_o(off), .run_o(run), .restart_o(restart),
        .compare_o(cmp_held), .prescale_o(pre_held)
    );

    bit_tick_gen #(.TIMER_W(TIMER_W), .PRE_W(PRE_W)) u_tick (
        .clk, .rst_n, .run_i(run), .restart_i(restart),
        .compare_i(cmp_held), .prescale_i(pre_held), .tick_o(bit_tick)
    );

    tx_shift_unit #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_shift (
        .clk, .rst_n, .load_i(load), .word_i(word), .preset_i(preset),
        .off_i(off), .tick_i(bit_tick), .line_o(tx_line), .wrap_o(wrap)
    );
endmodule

// File: rtl/uart_shift_tx_checker.sv
module uart_shift_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line,
    input logic bit_tick
);
    a_r1_ready_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_line);

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !tx_line);

    a_r10_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !(in_valid && in_ready)) |=> $stable(tx_line));

    a_r6_ready_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(bit_tick));
endmodule

bind uart_shift_tx uart_shift_tx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .tx_line(tx_line), .bit_tick(bit_tick)
);

// File: tb/uart_shift_tx_bench.sv
module uart_shift_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic [1:0] cfg_parity = '0;
    logic       cfg_two_stop = 1'b0;
    logic [7:0] cfg_compare = '0;
    logic       cfg_prescale8 = 1'b0;
    logic       tx_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    uart_shift_tx u_uart_shift_tx (
        .clk, .rst_n, .in_valid, .in_data, .in_ready,
        .cfg_parity, .cfg_two_stop, .cfg_compare, .cfg_prescale8, .tx_line
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Frame model: bit k is the k-th line value after acceptance.
    function automatic void build_frame(input logic [7:0] d, input logic [1:0] par,
                                        input logic two, output logic [11:0] b, output int nb);
        b  = '1;
        b[0] = 1'b0;
        for (int k = 0; k < 8; k++) b[k+1] = d[k];
        nb = 9;
        if (par == 2'b01 || par == 2'b10) begin
            b[9] = (^d) ^ (par == 2'b10);
            nb = 10;
        end
        nb = nb + (two ? 2 : 1);
    endfunction

    function automatic string bit_req(input int k, input int nb, input bit par_on);
        if (k == 0) return "R3 R8 start";
        if (k <= 8) return "R4 R7 data";
        if (k == 9 && par_on) return "R5 parity";
        return (k < nb) ? "R6 stop" : "R6";
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] par, input logic two,
                        input logic [7:0] cmp, input logic pre8, input bit disturb);
        logic [11:0] fr;
        int nb;
        int per;
        int bad;
        int bad_rdy;
        logic mid [12];
        build_frame(d, par, two, fr, nb);
        per = (int'(cmp) + 1) * (pre8 ? 8 : 1);
        @(negedge clk);
        check("R2 ready before offer", in_ready, 1'b1);
        in_data = d; cfg_parity = par; cfg_two_stop = two;
        cfg_compare = cmp; cfg_prescale8 = pre8; in_valid = 1'b1;
        @(negedge clk);
        if (disturb) begin
            in_valid = 1'b1; in_data = ~d;
            cfg_parity = par + 2'd1; cfg_two_stop = ~two;
            cfg_compare = cmp + 8'd1; cfg_prescale8 = ~pre8;
        end else begin
            in_valid = 1'b0;
        end
        bad = 0; bad_rdy = 0;
        for (int i = 0; i < nb * per; i++) begin
            if (tx_line !== fr[i / per]) bad++;
            if (in_ready !== 1'b0) bad_rdy++;
            if (i % per == per / 2) mid[i / per] = tx_line;
            if (i == nb * per - 1) in_valid = 1'b0;
            @(negedge clk);
        end
        for (int k = 0; k < nb; k++)
            check(disturb ? {bit_req(k, nb, nb > 10 || (nb == 10 && !two)), " R9"} : bit_req(k, nb, nb > 10 || (nb == 10 && !two)),
                  mid[k], fr[k]);
        check(disturb ? "R10 R9 whole-frame samples" : "R10 whole-frame samples", bad, 0);
        check("R2 ready low in frame", bad_rdy, 0);
        check("R6 ready back at frame end", in_ready, 1'b1);
        check("R1 idle line high", tx_line, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2023);
        repeat (3) @(negedge clk);
        check("R1 reset ready", in_ready, 1'b1);
        check("R1 reset line", tx_line, 1'b1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle line after reset", tx_line, 1'b1);
        send(8'h00, 2'b00, 1'b0, 8'd0, 1'b0, 1'b0);
        send(8'hFF, 2'b10, 1'b1, 8'd2, 1'b0, 1'b0);
        send(8'hA5, 2'b01, 1'b0, 8'd1, 1'b1, 1'b0);
        send(8'h01, 2'b11, 1'b1, 8'd3, 1'b0, 1'b1);
        send(8'h80, 2'b01, 1'b1, 8'd0, 1'b1, 1'b1);
        repeat (37) @(negedge clk);
        send(8'h6C, 2'b10, 1'b0, 8'd4, 1'b0, 1'b0);
        for (int n = 0; n < 30; n++) begin
            send(8'($urandom), 2'($urandom), 1'($urandom), 8'($urandom % 6),
                 1'($urandom), 1'($urandom));
            if ($urandom % 2) repeat ($urandom % 20) @(negedge clk);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule